// File: doc/BRIEF.md
# DMA Channel Transfer Sequencer

This block is the data mover of a single DMA channel. Software loads a source address, a destination address and a byte count, picks the beat width and address-step behaviour for each side, and sets the go bit. The channel then alternates between two phases. In the fetch phase it issues read beats into an internal byte-wide FIFO until one burst's worth of bytes has been read or the count is spent. In the drain phase it issues write beats out of the FIFO for as long as a full destination beat is buffered. Because the FIFO is byte-wide, the two sides may use different widths: a byte source can feed a word destination and the reverse.

When the count is exhausted and the FIFO has drained, a count-to-zero event is raised. If the count-reload register carries its enable bit, the channel copies the reload values into its working address and count registers, raises a reload flag and carries on without software help. Otherwise it goes idle. A bus error on either side raises an error flag and ends the run. All flags are sticky and cleared by writing ones to the flag register.

Both memory ports use valid/ready. A port raises valid with its address, size and, on the write side, its data, and holds all of them unchanged until the cycle in which ready is high; the beat completes in that cycle. The read data and the error response on either port are sampled in that same handshake cycle. Data on both ports is little-endian and right-justified: byte 0 of a beat sits in bits 7:0 and unused upper lanes are zero on writes and ignored on reads.

Top module: `dmach_engine`

## Requirements
- R1: After reset the channel is idle (st_active low), all three flags are low and neither rd_valid nor wr_valid is asserted; a configuration write to register 0 with bit 0 set while idle starts a run and raises st_active.
- R2: Width fields use 0 = byte, 1 = halfword, 2 = word, 3 treated as word; the source width sits in control bits 2:1 and the destination width in bits 5:4. Bytes reach the destination in the order they were read, so any source width can feed any destination width.
- R3: With its step bit set (bit 3 for source, bit 6 for destination) an address advances by the beat width of its side after each completed beat; with the bit clear it stays fixed.
- R4: The 24-bit count holds bytes and decreases by the source beat width on each good read beat, clamping at zero; a run started with count zero moves no data.
- R5: Control bits 12:8 hold a burst field B; a fetch phase ends once at least B+1 bytes have been read, so no more than B+1 bytes rounded up to a whole source beat are read between drain phases.
- R6: When the count is zero and every full destination beat has been written, st_ctz is set; without reload the channel then goes idle.
- R7: If bit 31 of the count-reload register (register 7) is set at count-to-zero, the working source, destination and count take the reload values (registers 5, 6, 7), st_reload is set and the channel keeps running; the reloaded addresses always have bit 31 clear.
- R8: A read beat with rd_err set stores no data and sets st_buserr; no further read is issued, already buffered bytes are still written, then the channel idles without setting st_ctz.
- R9: A write beat with wr_err set sets st_buserr, discards the FIFO and idles the channel at once.
- R10: Writing register 1 clears the flags whose bits are 1 (bit 0 count-to-zero, bit 1 reload, bit 2 bus error) and leaves the others.
- R11: While active, writes to the control, source, destination and count registers are ignored; the reload registers stay writable.
- R12: A valid held without ready keeps its address, size and data stable into the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 3 | Register select (0 control, 1 flags, 2 source, 3 destination, 4 count, 5/6/7 reload source/destination/count) |
| cfg_wdata | input | 32 | Configuration write data |
| rd_valid | output | 1 | Read beat request |
| rd_ready | input | 1 | Read beat accepted, data and error valid |
| rd_addr | output | AW | Read address |
| rd_size | output | 2 | Read beat width code |
| rd_rdata | input | 32 | Read data, right-justified |
| rd_err | input | 1 | Read error response |
| wr_valid | output | 1 | Write beat request |
| wr_ready | input | 1 | Write beat accepted, error valid |
| wr_addr | output | AW | Write address |
| wr_size | output | 2 | Write beat width code |
| wr_data | output | 32 | Write data, right-justified |
| wr_err | input | 1 | Write error response |
| st_active | output | 1 | Channel running |
| st_ctz | output | 1 | Count-to-zero flag |
| st_reload | output | 1 | Reload flag |
| st_buserr | output | 1 | Bus error flag |
| cur_src | output | AW | Working source address |
| cur_dst | output | AW | Working destination address |
| cur_cnt | output | CW | Working byte count |

## Verification
The hardest situation to reach is the reload turnover: the channel has to hit count-to-zero with reload armed and then stop cleanly after exactly one more pass, with no software step in between. The stimulus arms reload with a source reload value whose bit 31 is set, slows the memory responder to two beats in three, and disarms reload through the still-writable count-reload register as soon as the reload flag is seen. The second pass is long enough that this write lands before the pass ends. The error paths are reached by having the responder return an error on one chosen address, once on the read side and once on the write side.

// File: rtl/dmach_pkg.sv
package dmach_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FETCH = 2'd1,
    ST_DRAIN = 2'd2
  } dmach_state_e;

  localparam logic [2:0] SEL_CTRL    = 3'd0;
  localparam logic [2:0] SEL_FLAGS   = 3'd1;
  localparam logic [2:0] SEL_SRC     = 3'd2;
  localparam logic [2:0] SEL_DST     = 3'd3;
  localparam logic [2:0] SEL_CNT     = 3'd4;
  localparam logic [2:0] SEL_SRC_RLD = 3'd5;
  localparam logic [2:0] SEL_DST_RLD = 3'd6;
  localparam logic [2:0] SEL_CNT_RLD = 3'd7;

  // width code to bytes per beat; code 3 falls back to a word
  function automatic logic [2:0] beat_bytes(input logic [1:0] code);
    case (code)
      2'd0:    beat_bytes = 3'd1;
      2'd1:    beat_bytes = 3'd2;
      default: beat_bytes = 3'd4;
    endcase
  endfunction

endpackage

// File: rtl/dmach_addr_step.sv
module dmach_addr_step #(
  parameter int AW = 32
) (
  input  logic [AW-1:0] base,
  input  logic [1:0]    width,
  input  logic          step_en,
  output logic [AW-1:0] next
);
  import dmach_pkg::*;

  logic [2:0] nbytes;

  always_comb begin
    nbytes = beat_bytes(width);
    next   = step_en ? (base + AW'(nbytes)) : base;
  end

endmodule

// File: rtl/dmach_byte_fifo.sv
module dmach_byte_fifo #(
  parameter int DEPTH = 64
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       flush,
  input  logic                       push,
  input  logic [2:0]                 push_n,
  input  logic [31:0]                push_data,
  input  logic                       pop,
  input  logic [2:0]                 pop_n,
  output logic [31:0]                pop_data,
  output logic [$clog2(DEPTH):0]     level
);
  localparam int PW = $clog2(DEPTH);
  localparam int LW = PW + 1;

  logic [7:0]    mem [DEPTH];
  logic [PW-1:0] wp, rp;

  always_ff @(posedge clk) begin
    if (push && !flush) begin
      for (int i = 0; i < 4; i++) begin
        if (3'(i) < push_n) mem[wp + PW'(i)] <= push_data[8*i +: 8];
      end
    end
  end

  always_comb begin
    pop_data = '0;
    for (int i = 0; i < 4; i++) begin
      if (3'(i) < pop_n) pop_data[8*i +: 8] = mem[rp + PW'(i)];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp    <= '0;
      rp    <= '0;
      level <= '0;
    end else if (flush) begin
      wp    <= '0;
      rp    <= '0;
      level <= '0;
    end else begin
      if (push) wp <= wp + PW'(push_n);
      if (pop)  rp <= rp + PW'(pop_n);
      level <= level + (push ? LW'(push_n) : LW'(0)) - (pop ? LW'(pop_n) : LW'(0));
    end
  end

  AST_FIFO_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> ({1'b0, level} + (LW+1)'(push_n) <= (LW+1)'(DEPTH))); // R5

  AST_FIFO_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> (level >= LW'(pop_n))); // R2

endmodule

// File: rtl/dmach_engine.sv
module dmach_engine #(
  parameter int AW         = 32,
  parameter int CW         = 24,
  parameter int BURST_W    = 5,
  parameter int FIFO_DEPTH = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [2:0]    cfg_sel,
  input  logic [31:0]   cfg_wdata,
  output logic          rd_valid,
  input  logic          rd_ready,
  output logic [AW-1:0] rd_addr,
  output logic [1:0]    rd_size,
  input  logic [31:0]   rd_rdata,
  input  logic          rd_err,
  output logic          wr_valid,
  input  logic          wr_ready,
  output logic [AW-1:0] wr_addr,
  output logic [1:0]    wr_size,
  output logic [31:0]   wr_data,
  input  logic          wr_err,
  output logic          st_active,
  output logic          st_ctz,
  output logic          st_reload,
  output logic          st_buserr,
  output logic [AW-1:0] cur_src,
  output logic [AW-1:0] cur_dst,
  output logic [CW-1:0] cur_cnt
);
  import dmach_pkg::*;

  localparam int LW  = $clog2(FIFO_DEPTH) + 1;
  localparam int BAW = BURST_W + 2;

  dmach_state_e state;

  // configuration
  logic [1:0]         c_sw, c_dw;
  logic               c_si, c_di;
  logic [BURST_W-1:0] c_burst;
  logic [AW-2:0]      rld_src, rld_dst;
  logic [CW-1:0]      rld_cnt;
  logic               rld_en;

  // working state
  logic [AW-1:0] src_q, dst_q;
  logic [CW-1:0] cnt_q;
  logic [BAW-1:0] burst_acc;
  logic           rd_fail;

  // derived
  logic [2:0]     sbytes, dbytes;
  logic [BAW-1:0] burst_bytes;
  logic           more_rd, rd_fire, wr_fire, can_wr, drained;
  logic           ctz_evt, reload_evt, fifo_flush, bus_evt;
  logic [AW-1:0]  src_next, dst_next;
  logic [CW-1:0]  cnt_next;
  logic [LW-1:0]  level;
  logic [31:0]    fifo_out;
  logic           cfg_idle_wr, start;
  logic [2:0]     flag_clr;

  dmach_addr_step #(.AW(AW)) u_src_step (
    .base(src_q), .width(c_sw), .step_en(c_si), .next(src_next)
  );

  dmach_addr_step #(.AW(AW)) u_dst_step (
    .base(dst_q), .width(c_dw), .step_en(c_di), .next(dst_next)
  );

  dmach_byte_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (fifo_flush),
    .push      (rd_fire && !rd_err),
    .push_n    (sbytes),
    .push_data (rd_rdata),
    .pop       (wr_fire),
    .pop_n     (dbytes),
    .pop_data  (fifo_out),
    .level     (level)
  );

  always_comb begin
    sbytes      = beat_bytes(c_sw);
    dbytes      = beat_bytes(c_dw);
    burst_bytes = BAW'(c_burst) + BAW'(1);
    more_rd     = (burst_acc < burst_bytes) && (cnt_q != '0) && !rd_fail;
    rd_valid    = (state == ST_FETCH) && more_rd;
    rd_fire     = rd_valid && rd_ready;
    can_wr      = level >= LW'(dbytes);
    wr_valid    = (state == ST_DRAIN) && can_wr;
    wr_fire     = wr_valid && wr_ready;
    drained     = (state == ST_DRAIN) && !can_wr;
    ctz_evt     = drained && !rd_fail && (cnt_q == '0);
    reload_evt  = ctz_evt && rld_en;
    bus_evt     = (rd_fire && rd_err) || (wr_fire && wr_err);
    fifo_flush  = (wr_fire && wr_err) || ctz_evt || (drained && rd_fail);
    cnt_next    = (cnt_q <= CW'(sbytes)) ? '0 : (cnt_q - CW'(sbytes));
    cfg_idle_wr = cfg_we && (state == ST_IDLE);
    start       = cfg_idle_wr && (cfg_sel == SEL_CTRL) && cfg_wdata[0];
    flag_clr    = (cfg_we && cfg_sel == SEL_FLAGS) ? cfg_wdata[2:0] : 3'b000;
  end

  assign rd_addr   = src_q;
  assign rd_size   = c_sw;
  assign wr_addr   = dst_q;
  assign wr_size   = c_dw;
  assign wr_data   = fifo_out;
  assign st_active = (state != ST_IDLE);
  assign cur_src   = src_q;
  assign cur_dst   = dst_q;
  assign cur_cnt   = cnt_q;

  // reload registers: writable at any time
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rld_src <= '0;
      rld_dst <= '0;
      rld_cnt <= '0;
      rld_en  <= 1'b0;
    end else if (cfg_we) begin
      case (cfg_sel)
        SEL_SRC_RLD: rld_src <= cfg_wdata[AW-2:0];
        SEL_DST_RLD: rld_dst <= cfg_wdata[AW-2:0];
        SEL_CNT_RLD: begin
          rld_cnt <= cfg_wdata[CW-1:0];
          rld_en  <= cfg_wdata[31];
        end
        default: ;
      endcase
    end
  end

  // sticky flags, set wins over clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_ctz    <= 1'b0;
      st_reload <= 1'b0;
      st_buserr <= 1'b0;
    end else begin
      st_ctz    <= (st_ctz    & ~flag_clr[0]) | ctz_evt;
      st_reload <= (st_reload & ~flag_clr[1]) | reload_evt;
      st_buserr <= (st_buserr & ~flag_clr[2]) | bus_evt;
    end
  end

  // control, working registers and sequencer
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      c_sw      <= 2'd0;
      c_dw      <= 2'd0;
      c_si      <= 1'b0;
      c_di      <= 1'b0;
      c_burst   <= '0;
      src_q     <= '0;
      dst_q     <= '0;
      cnt_q     <= '0;
      burst_acc <= '0;
      rd_fail   <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (cfg_idle_wr) begin
            case (cfg_sel)
              SEL_CTRL: begin
                c_sw    <= cfg_wdata[2:1];
                c_si    <= cfg_wdata[3];
                c_dw    <= cfg_wdata[5:4];
                c_di    <= cfg_wdata[6];
                c_burst <= cfg_wdata[8 +: BURST_W];
              end
              SEL_SRC: src_q <= cfg_wdata[AW-1:0];
              SEL_DST: dst_q <= cfg_wdata[AW-1:0];
              SEL_CNT: cnt_q <= cfg_wdata[CW-1:0];
              default: ;
            endcase
          end
          if (start) begin
            state     <= ST_FETCH;
            burst_acc <= '0;
            rd_fail   <= 1'b0;
          end
        end
        ST_FETCH: begin
          if (rd_fire && rd_err) begin
            rd_fail <= 1'b1;
            state   <= ST_DRAIN;
          end else if (rd_fire) begin
            src_q     <= src_next;
            cnt_q     <= cnt_next;
            burst_acc <= burst_acc + BAW'(sbytes);
          end else if (!more_rd) begin
            state <= ST_DRAIN;
          end
        end
        ST_DRAIN: begin
          if (wr_fire && wr_err) begin
            state <= ST_IDLE;
          end else if (wr_fire) begin
            dst_q <= dst_next;
          end else if (drained) begin
            burst_acc <= '0;
            if (rd_fail) begin
              state <= ST_IDLE;
            end else if (cnt_q == '0) begin
              if (rld_en) begin
                src_q <= {1'b0, rld_src};
                dst_q <= {1'b0, rld_dst};
                cnt_q <= rld_cnt;
                state <= ST_FETCH;
              end else begin
                state <= ST_IDLE;
              end
            end else begin
              state <= ST_FETCH;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_addr) && $stable(rd_size))); // R12

  AST_WR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_addr) && $stable(wr_data))); // R12

  AST_CNT_NO_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    (st_active && !reload_evt) |=> (cur_cnt <= $past(cur_cnt))); // R4

  AST_RD_ERR_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_fire && rd_err) |=> !rd_valid); // R8

  AST_RELOAD_HIGH_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    reload_evt |=> (!cur_src[AW-1] && !cur_dst[AW-1] && st_reload)); // R7

  AST_WR_ERR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fire && wr_err) |=> (!st_active && st_buserr)); // R9

endmodule

// File: tb/dmach_engine_tb_top.sv
module dmach_engine_tb_top;

  localparam int AW = 32;
  localparam int CW = 24;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_we = 1'b0;
  logic [2:0]    cfg_sel = '0;
  logic [31:0]   cfg_wdata = '0;
  logic          rd_valid, wr_valid;
  logic          rd_ready = 1'b0, wr_ready = 1'b0;
  logic [AW-1:0] rd_addr, wr_addr;
  logic [1:0]    rd_size, wr_size;
  logic [31:0]   rd_rdata = '0, wr_data;
  logic          rd_err = 1'b0, wr_err = 1'b0;
  logic          st_active, st_ctz, st_reload, st_buserr;
  logic [AW-1:0] cur_src, cur_dst;
  logic [CW-1:0] cur_cnt;

  always #10 clk = ~clk;

  dmach_engine dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_addr(rd_addr), .rd_size(rd_size),
    .rd_rdata(rd_rdata), .rd_err(rd_err),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_size(wr_size),
    .wr_data(wr_data), .wr_err(wr_err),
    .st_active(st_active), .st_ctz(st_ctz), .st_reload(st_reload), .st_buserr(st_buserr),
    .cur_src(cur_src), .cur_dst(cur_dst), .cur_cnt(cur_cnt)
  );

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  // memory responder state
  logic [7:0]  dmem [1024];
  bit          stall_en = 1'b0;
  bit          err_rd_en = 1'b0, err_wr_en = 1'b0;
  logic [31:0] err_addr = '0;
  int          cyc = 0, nrd = 0, nwr = 0, run = 0, max_run = 0;

  function automatic logic [7:0] sbyte(input logic [31:0] a);
    return (a[7:0] * 8'd7) ^ a[15:8] ^ 8'h3C;
  endfunction

  function automatic int nb(input logic [1:0] code);
    return (code == 2'd0) ? 1 : (code == 2'd1) ? 2 : 4;
  endfunction

  always @(negedge clk) begin
    bit allow;
    cyc++;
    allow = !stall_en || (cyc % 3 != 0);
    rd_ready = rd_valid && allow;
    rd_err   = rd_valid && err_rd_en && (rd_addr == err_addr);
    rd_rdata = '0;
    for (int i = 0; i < nb(rd_size); i++) rd_rdata[8*i +: 8] = sbyte(rd_addr + 32'(i));
    wr_ready = wr_valid && allow;
    wr_err   = wr_valid && err_wr_en && (wr_addr == err_addr);
    if (rd_valid && rd_ready) begin
      nrd++;
      run++;
      if (run > max_run) max_run = run;
    end
    if (wr_valid && wr_ready) begin
      run = 0;
      if (!wr_err) begin
        nwr++;
        for (int i = 0; i < nb(wr_size); i++) dmem[10'(wr_addr + 32'(i))] = wr_data[8*i +: 8];
      end
    end
  end

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic cfg(input logic [2:0] sel, input logic [31:0] data);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = data;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  function automatic logic [31:0] ctrl(input logic [1:0] sw, input bit si, input logic [1:0] dw,
                                       input bit di, input logic [4:0] burst);
    return {19'd0, burst, 1'b0, di, dw, si, sw, 1'b1};
  endfunction

  task automatic prep();
    for (int i = 0; i < 1024; i++) dmem[i] = 8'h00;
    nrd = 0; nwr = 0; run = 0; max_run = 0;
    cfg(3'd1, 32'h7);
  endtask

  task automatic launch(input logic [31:0] s, input logic [31:0] d, input logic [31:0] n, input logic [31:0] c);
    cfg(3'd2, s);
    cfg(3'd3, d);
    cfg(3'd4, n);
    cfg(3'd0, c);
  endtask

  task automatic wait_idle(input string req);
    int t = 0;
    while (st_active && t < 5000) begin
      @(negedge clk);
      t++;
    end
    chk(req, "channel returned to idle", 32'(st_active), 32'd0);
  endtask

  function automatic int bad_bytes(input int d, input int s, input int n);
    int bad = 0;
    for (int k = 0; k < n; k++) if (dmem[10'(d + k)] !== sbyte(32'(s + k))) bad++;
    return bad;
  endfunction

  task automatic t_reset();
    chk("R1", "active after reset", 32'(st_active), 0);
    chk("R1", "flags after reset", {29'd0, st_ctz, st_reload, st_buserr}, 0);
    chk("R1", "no beats after reset", {30'd0, rd_valid, wr_valid}, 0);
  endtask

  task automatic t_word_copy();
    prep();
    launch(32'h100, 32'h200, 32'd16, ctrl(2'd2, 1, 2'd2, 1, 5'd7));
    chk("R1", "go bit starts run", 32'(st_active), 1);
    wait_idle("R6");
    chk("R2", "word copy data", bad_bytes(32'h200, 32'h100, 16), 0);
    chk("R3", "source advanced", cur_src, 32'h110);
    chk("R3", "destination advanced", cur_dst, 32'h210);
    chk("R4", "count spent", 32'(cur_cnt), 0);
    chk("R6", "count-to-zero flag", 32'(st_ctz), 1);
  endtask

  task automatic t_byte_to_word();
    prep();
    stall_en = 1'b1;
    launch(32'h040, 32'h300, 32'd8, ctrl(2'd0, 1, 2'd1 + 2'd1, 1, 5'd31));
    wait_idle("R2");
    stall_en = 1'b0;
    chk("R2", "byte source packed into words", bad_bytes(32'h300, 32'h040, 8), 0);
    chk("R2", "two word writes", 32'(nwr), 2);
    chk("R4", "eight byte reads", 32'(nrd), 8);
  endtask

  task automatic t_fixed_src();
    int bad = 0;
    prep();
    launch(32'h050, 32'h320, 32'd6, ctrl(2'd1, 0, 2'd0, 1, 5'd31));
    wait_idle("R3");
    for (int k = 0; k < 6; k++) if (dmem[10'(32'h320 + k)] !== sbyte(32'h050 + 32'(k % 2))) bad++;
    chk("R3", "fixed source repeats", 32'(bad), 0);
    chk("R3", "source held", cur_src, 32'h050);
    chk("R4", "halfword count steps", 32'(nrd), 3);
  endtask

  task automatic t_fixed_dst();
    prep();
    launch(32'h060, 32'h340, 32'd8, ctrl(2'd2, 1, 2'd0, 0, 5'd31));
    wait_idle("R3");
    chk("R3", "destination held", cur_dst, 32'h340);
    chk("R3", "last byte at fixed address", 32'(dmem[10'h340]), 32'(sbyte(32'h067)));
    chk("R2", "byte writes from words", 32'(nwr), 8);
  endtask

  task automatic t_burst();
    prep();
    launch(32'h070, 32'h360, 32'd12, ctrl(2'd0, 1, 2'd0, 1, 5'd3));
    wait_idle("R5");
    chk("R5", "reads per burst", 32'(max_run), 4);
    chk("R5", "burst copy data", bad_bytes(32'h360, 32'h070, 12), 0);
  endtask

  task automatic t_reload();
    int t = 0;
    prep();
    stall_en = 1'b1;
    cfg(3'd5, 32'h8000_00A0);
    cfg(3'd6, 32'h0000_03A0);
    cfg(3'd7, 32'h8000_0010);
    launch(32'h080, 32'h380, 32'd4, ctrl(2'd2, 1, 2'd2, 1, 5'd31));
    while (!st_reload && t < 2000) begin
      @(negedge clk);
      t++;
    end
    cfg(3'd7, 32'h0);
    wait_idle("R7");
    stall_en = 1'b0;
    chk("R7", "reload flag", 32'(st_reload), 1);
    chk("R7", "reloaded source bit 31 clear", cur_src, 32'h0000_00B0);
    chk("R7", "reloaded destination", cur_dst, 32'h0000_03B0);
    chk("R7", "first pass data", bad_bytes(32'h380, 32'h080, 4), 0);
    chk("R7", "second pass data", bad_bytes(32'h3A0, 32'h0A0, 16), 0);
    chk("R6", "ctz after second pass", 32'(st_ctz), 1);
  endtask

  task automatic t_clear();
    cfg(3'd1, 32'h2);
    chk("R10", "reload flag cleared", 32'(st_reload), 0);
    chk("R10", "ctz flag kept", 32'(st_ctz), 1);
    cfg(3'd1, 32'h1);
    chk("R10", "ctz flag cleared", 32'(st_ctz), 0);
  endtask

  task automatic t_ignore();
    prep();
    stall_en = 1'b1;
    launch(32'h0C0, 32'h3C0, 32'd16, ctrl(2'd2, 1, 2'd2, 1, 5'd31));
    cfg(3'd2, 32'h000);
    cfg(3'd4, 32'd4);
    cfg(3'd0, ctrl(2'd0, 0, 2'd0, 0, 5'd0));
    wait_idle("R11");
    stall_en = 1'b0;
    chk("R11", "source write ignored", cur_src, 32'h0D0);
    chk("R11", "count write ignored", 32'(nrd), 4);
    chk("R11", "control write ignored", bad_bytes(32'h3C0, 32'h0C0, 16), 0);
  endtask

  task automatic t_rd_err();
    prep();
    err_addr = 32'h108; err_rd_en = 1'b1;
    launch(32'h100, 32'h200, 32'd16, ctrl(2'd2, 1, 2'd2, 1, 5'd31));
    wait_idle("R8");
    err_rd_en = 1'b0;
    chk("R8", "bus error flag", 32'(st_buserr), 1);
    chk("R8", "no ctz on error", 32'(st_ctz), 0);
    chk("R8", "count after error", 32'(cur_cnt), 8);
    chk("R8", "buffered bytes written", 32'(nwr), 2);
    chk("R8", "good data kept", bad_bytes(32'h200, 32'h100, 8), 0);
  endtask

  task automatic t_wr_err();
    prep();
    err_addr = 32'h202; err_wr_en = 1'b1;
    launch(32'h100, 32'h200, 32'd8, ctrl(2'd2, 1, 2'd0, 1, 5'd31));
    wait_idle("R9");
    err_wr_en = 1'b0;
    chk("R9", "bus error flag", 32'(st_buserr), 1);
    chk("R9", "writes stop at error", 32'(nwr), 2);
    chk("R9", "destination at error", cur_dst, 32'h202);
    chk("R9", "no ctz on write error", 32'(st_ctz), 0);
  endtask

  task automatic t_zero();
    prep();
    launch(32'h100, 32'h200, 32'd0, ctrl(2'd2, 1, 2'd2, 1, 5'd31));
    wait_idle("R4");
    chk("R4", "zero count reads nothing", 32'(nrd), 0);
    chk("R6", "zero count sets ctz", 32'(st_ctz), 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_word_copy();
    t_byte_to_word();
    t_fixed_src();
    t_fixed_dst();
    t_burst();
    t_reload();
    t_clear();
    t_ignore();
    t_rd_err();
    t_wr_err();
    t_zero();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

endmodule